// File: doc/BRIEF.md
# Byte-Enable to Dword-Length Encoder

This block takes one transfer, given as a start byte address, a direction and a byte-strobe vector over a wide internal data word, and turns it into the framing fields that a packet link needs. These fields are a length counted in 32-bit dwords, a byte enable for the first dword, a byte enable for the last dword, and the dword address of the first byte moved. The exact byte count travels only in the two enables. The length counts the dwords touched.

Strobe bit k stands for the byte at address `inAddr + k`, so the start address sets the lane at which the run begins inside its first dword. The encoder requires the set strobes to form one unbroken run. It raises a flag when a clear strobe lies between the first and the last set strobe. A read of zero bytes is turned into a one-dword read with every lane enabled. A write of zero bytes is passed on as a zero-length write. One register stage separates the inputs from the outputs.

Top module: `beDwordEncoder`

## Requirements
- R1: Strobe bit k refers to byte address inAddr+k; outDwAddr equals (inAddr + index of lowest set strobe) shifted right by 2, computed modulo 2^ADDR_W.
- R2: With at least one strobe set, outLenDw equals the number of 32-bit dwords touched by the byte span from the lowest to the highest set strobe, counting from address inAddr.
- R3: outFirstBe bit j (j = 0..3, bit j = byte lane j, lane = address bits [1:0]) is set exactly when lane j of the first touched dword lies inside that span.
- R4: When the span touches two or more dwords, outLastBe bit j is set exactly when lane j of the final dword lies at or below the span's last byte; when it touches one dword, outLastBe is 4'h0.
- R5: outBadStrb is 1 exactly when some strobe is clear between the lowest and highest set strobe, for reads and writes alike; the other fields are still derived from the span.
- R6: A read (inIsWrite = 0) with all strobes clear gives outLenDw = 1, outFirstBe = 4'hF, outLastBe = 4'h0, outDwAddr = inAddr >> 2 and outBadStrb = 0.
- R7: A write (inIsWrite = 1) with all strobes clear gives outLenDw = 1, outFirstBe = 4'h0, outLastBe = 4'h0, outDwAddr = inAddr >> 2 and outBadStrb = 0.
- R8: The outputs show the result for an input accepted with inValid = 1 at a clock edge right after that edge; outValid is high for exactly the cycles that follow an accepted input, and all field outputs hold their values after a cycle with inValid = 0.
- R9: While rstN is low, outValid and every field output are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A transfer is presented this cycle |
| inIsWrite | input | 1 | 1 = write, 0 = read |
| inAddr | input | ADDR_W | Byte address of strobe bit 0 |
| inStrb | input | BUS_BYTES | Byte strobes, bit k = byte inAddr+k |
| outValid | output | 1 | Fields below belong to a newly accepted transfer |
| outLenDw | output | LEN_W | Length in 32-bit dwords |
| outFirstBe | output | 4 | Byte enable of the first dword |
| outLastBe | output | 4 | Byte enable of the last dword |
| outDwAddr | output | ADDR_W-2 | Dword address of the first byte moved |
| outBadStrb | output | 1 | Strobe pattern has a gap |

## Verification
The assertions assume that inputs are stable around the sampling edge and that no X values reach the strobe and direction pins during a valid cycle. They also assume that a clean run of strobes never leaves a gap, so the checks on the edge lanes (first enable reaching lane 3, last enable starting at lane 0) apply only when outBadStrb is low. The stimulus drives inputs only at falling edges with defined values. It mixes contiguous runs at every start lane, random and deliberately gapped patterns, and both zero-strobe cases, and it inserts idle cycles so that the hold behaviour is checked.

// File: rtl/beEncPkg.sv
package beEncPkg;
  typedef struct packed {
    logic capture;    // register the fields this cycle
    logic zeroRead;   // read with no strobe set
    logic zeroWrite;  // write with no strobe set
  } encCtrl_t;
endpackage

// File: rtl/beEncCtrl.sv
module beEncCtrl
  import beEncPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inIsWrite,
  input  logic     anyStrb,
  output encCtrl_t ctl,
  output logic     outValid
);
  always_comb begin
    ctl.capture   = inValid;
    ctl.zeroRead  = inValid && !inIsWrite && !anyStrb;
    ctl.zeroWrite = inValid && inIsWrite && !anyStrb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/beEncDatapath.sv
module beEncDatapath
  import beEncPkg::*;
#(
  parameter int BUS_BYTES = 16,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(BUS_BYTES),
  localparam int POS_W    = $clog2(BUS_BYTES + 3) + 1,
  localparam int DW_W     = POS_W - 2,
  localparam int LEN_W    = $clog2(BUS_BYTES / 4 + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  encCtrl_t             ctl,
  input  logic [ADDR_W-1:0]    inAddr,
  input  logic [BUS_BYTES-1:0] inStrb,
  output logic                 anyStrb,
  output logic [LEN_W-1:0]     outLenDw,
  output logic [3:0]           outFirstBe,
  output logic [3:0]           outLastBe,
  output logic [ADDR_W-3:0]    outDwAddr,
  output logic                 outBadStrb
);
  logic [IDX_W-1:0] firstIdx, lastIdx;
  logic [IDX_W:0]   setCount, spanBytes;
  logic             seen;
  logic [POS_W-1:0] startPos, endPos;
  logic [DW_W-1:0]  firstDw, lastDw, spanDw;
  logic [3:0]       feNext, leNext;

  // locate the run bounds and count the set strobes
  always_comb begin
    firstIdx = '0;
    lastIdx  = '0;
    setCount = '0;
    seen     = 1'b0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (inStrb[i]) begin
        if (!seen) firstIdx = IDX_W'(i);
        seen     = 1'b1;
        lastIdx  = IDX_W'(i);
        setCount = setCount + 1'b1;
      end
    end
  end

  assign anyStrb   = |inStrb;
  assign spanBytes = {1'b0, lastIdx} - {1'b0, firstIdx} + (IDX_W+1)'(1);
  assign startPos  = POS_W'(inAddr[1:0]) + POS_W'(firstIdx);
  assign endPos    = POS_W'(inAddr[1:0]) + POS_W'(lastIdx);
  assign firstDw   = startPos[POS_W-1:2];
  assign lastDw    = endPos[POS_W-1:2];
  assign spanDw    = lastDw - firstDw + DW_W'(1);

  // per-lane enables for the first and final dword of the span
  for (genvar j = 0; j < 4; j++) begin : g_lane
    logic [POS_W-1:0] firstLanePos, lastLanePos;
    assign firstLanePos = {firstDw, 2'b00} + POS_W'(j);
    assign lastLanePos  = {lastDw, 2'b00} + POS_W'(j);
    assign feNext[j] = (firstLanePos >= startPos) && (firstLanePos <= endPos);
    assign leNext[j] = (lastDw != firstDw) && (lastLanePos <= endPos);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLenDw   <= '0;
      outFirstBe <= '0;
      outLastBe  <= '0;
      outDwAddr  <= '0;
      outBadStrb <= 1'b0;
    end else if (ctl.capture) begin
      outDwAddr <= inAddr[ADDR_W-1:2] + (ADDR_W-2)'(firstDw);
      if (ctl.zeroRead || ctl.zeroWrite) begin
        outLenDw   <= LEN_W'(1);
        outFirstBe <= ctl.zeroRead ? 4'hF : 4'h0;
        outLastBe  <= 4'h0;
        outBadStrb <= 1'b0;
      end else begin
        outLenDw   <= LEN_W'(spanDw);
        outFirstBe <= feNext;
        outLastBe  <= leNext;
        outBadStrb <= (setCount != spanBytes);
      end
    end
  end
endmodule

// File: rtl/beDwordEncoder.sv
module beDwordEncoder
  import beEncPkg::*;
#(
  parameter int BUS_BYTES = 16,
  parameter int ADDR_W    = 32,
  localparam int LEN_W    = $clog2(BUS_BYTES / 4 + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inIsWrite,
  input  logic [ADDR_W-1:0]    inAddr,
  input  logic [BUS_BYTES-1:0] inStrb,
  output logic                 outValid,
  output logic [LEN_W-1:0]     outLenDw,
  output logic [3:0]           outFirstBe,
  output logic [3:0]           outLastBe,
  output logic [ADDR_W-3:0]    outDwAddr,
  output logic                 outBadStrb
);
  encCtrl_t ctl;
  logic     anyStrb;

  beEncCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsWrite(inIsWrite),
    .anyStrb(anyStrb), .ctl(ctl), .outValid(outValid)
  );

  beEncDatapath #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inAddr(inAddr), .inStrb(inStrb),
    .anyStrb(anyStrb), .outLenDw(outLenDw), .outFirstBe(outFirstBe),
    .outLastBe(outLastBe), .outDwAddr(outDwAddr), .outBadStrb(outBadStrb)
  );
endmodule

// File: rtl/beEncChecker.sv
module beEncChecker #(
  parameter int BUS_BYTES = 16,
  parameter int ADDR_W    = 32,
  localparam int LEN_W    = $clog2(BUS_BYTES / 4 + 2)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inIsWrite,
  input logic [ADDR_W-1:0]    inAddr,
  input logic [BUS_BYTES-1:0] inStrb,
  input logic                 outValid,
  input logic [LEN_W-1:0]     outLenDw,
  input logic [3:0]           outFirstBe,
  input logic [3:0]           outLastBe,
  input logic [ADDR_W-3:0]    outDwAddr,
  input logic                 outBadStrb
);
  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R8
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outLenDw) && $stable(outFirstBe) && $stable(outLastBe)
                  && $stable(outDwAddr) && $stable(outBadStrb)));
  // R6
  zero_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsWrite && inStrb == '0) |=>
      (outLenDw == LEN_W'(1) && outFirstBe == 4'hF && outLastBe == 4'h0 && !outBadStrb));
  // R7
  zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inIsWrite && inStrb == '0) |=>
      (outLenDw == LEN_W'(1) && outFirstBe == 4'h0 && outLastBe == 4'h0 && !outBadStrb));
  // R4
  last_be_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outLenDw == LEN_W'(1)) == (outLastBe == 4'h0)));
  // R3
  edge_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outBadStrb && outLenDw > LEN_W'(1)) |-> (outFirstBe[3] && outLastBe[0]));
  // R2
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLenDw != '0));
endmodule

bind beDwordEncoder beEncChecker #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inIsWrite(inIsWrite),
  .inAddr(inAddr), .inStrb(inStrb), .outValid(outValid), .outLenDw(outLenDw),
  .outFirstBe(outFirstBe), .outLastBe(outLastBe), .outDwAddr(outDwAddr),
  .outBadStrb(outBadStrb)
);

// File: tb/beDwordEncoder_bench.sv
`timescale 1ns/1ps
module beDwordEncoder_bench;
  localparam int BUS_BYTES = 16;
  localparam int ADDR_W    = 32;
  localparam int LEN_W     = $clog2(BUS_BYTES / 4 + 2);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 inIsWrite = 1'b0;
  logic [ADDR_W-1:0]    inAddr = '0;
  logic [BUS_BYTES-1:0] inStrb = '0;
  logic                 outValid;
  logic [LEN_W-1:0]     outLenDw;
  logic [3:0]           outFirstBe, outLastBe;
  logic [ADDR_W-3:0]    outDwAddr;
  logic                 outBadStrb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit compareOn = 1'b0;

  // reference state
  int          expValid, expLen, expFe, expLe, expBad;
  logic [ADDR_W-3:0] expDw;
  string       expTag;

  always #5 clk = ~clk;

  beDwordEncoder #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_beDwordEncoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsWrite(inIsWrite),
    .inAddr(inAddr), .inStrb(inStrb), .outValid(outValid), .outLenDw(outLenDw),
    .outFirstBe(outFirstBe), .outLastBe(outLastBe), .outDwAddr(outDwAddr),
    .outBadStrb(outBadStrb)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0; expLen = 0; expFe = 0; expLe = 0; expBad = 0; expDw = '0;
      expTag = "R9";
    end else begin
      expValid = inValid;
      if (inValid) begin
        int f, l, s, e;
        logic [ADDR_W-1:0] a;
        f = -1; l = -1;
        for (int k = 0; k < BUS_BYTES; k++)
          if (inStrb[k]) begin
            if (f < 0) f = k;
            l = k;
          end
        if (f < 0) begin
          expLen = 1; expLe = 0; expBad = 0;
          expFe  = inIsWrite ? 0 : 'hF;
          expDw  = inAddr[ADDR_W-1:2];
          expTag = inIsWrite ? "R7" : "R6";
        end else begin
          s = int'(inAddr[1:0]) + f;
          e = int'(inAddr[1:0]) + l;
          expLen = e / 4 - s / 4 + 1;
          expFe = 0; expLe = 0; expBad = 0;
          for (int j = 0; j < 4; j++) begin
            if ((s / 4) * 4 + j >= s && (s / 4) * 4 + j <= e) expFe |= (1 << j);
            if (expLen > 1 && (e / 4) * 4 + j <= e) expLe |= (1 << j);
          end
          for (int k = f; k <= l; k++) if (!inStrb[k]) expBad = 1;
          a = inAddr + ADDR_W'(f);
          expDw = a[ADDR_W-1:2];
          expTag = "R1-R5";
        end
      end
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (compareOn) begin
      check("R8 outValid", int'(outValid), expValid);
      check({expTag == "R1-R5" ? "R2" : expTag, " outLenDw"}, int'(outLenDw), expLen);
      check({expTag == "R1-R5" ? "R3" : expTag, " outFirstBe"}, int'(outFirstBe), expFe);
      check({expTag == "R1-R5" ? "R4" : expTag, " outLastBe"}, int'(outLastBe), expLe);
      check({expTag == "R1-R5" ? "R5" : expTag, " outBadStrb"}, int'(outBadStrb), expBad);
      check({expTag == "R1-R5" ? "R1" : expTag, " outDwAddr"}, int'(outDwAddr), int'(expDw));
    end
  end

  task automatic send(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [BUS_BYTES-1:0] s);
    @(negedge clk);
    inValid = 1'b1; inIsWrite = wr; inAddr = a; inStrb = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inStrb = $urandom;  // ignored while not valid
      inAddr = $urandom;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check("R9 outValid", int'(outValid), 0);
    check("R9 outLenDw", int'(outLenDw), 0);
    check("R9 outFirstBe", int'(outFirstBe), 0);
    rstN = 1'b1;
    compareOn = 1'b1;

    send(1, 32'h1000, 16'h000F);   // one aligned dword
    send(1, 32'h1001, 16'h0003);   // lanes 1..2 only
    send(1, 32'h1003, 16'h0003);   // crosses into second dword
    send(1, 32'h2000, 16'hFFFF);   // full bus word, four dwords
    send(1, 32'h2003, 16'hFFFF);   // full word offset 3, five dwords
    send(0, 32'h3002, 16'h0000);   // R6 zero read
    send(1, 32'h3002, 16'h0000);   // R7 zero write
    send(1, 32'h4000, 16'h0F0F);   // R5 gap
    send(0, 32'h4001, 16'h8001);   // R5 gap on read
    idle(3);                       // R8 hold
    send(1, 32'hFFFF_FFFE, 16'h0010); // R1 address wrap
    send(0, 32'h5004, 16'h8000);   // single high byte
    idle(1);

    for (int n = 0; n < 300; n++) begin
      int lo, len;
      logic [BUS_BYTES-1:0] s;
      lo  = $urandom_range(0, BUS_BYTES - 1);
      len = $urandom_range(1, BUS_BYTES - lo);
      s = '0;
      for (int k = lo; k < lo + len; k++) s[k] = 1'b1;
      case ($urandom_range(0, 5))
        0: s = $urandom;
        1: s = '0;
        default: ;
      endcase
      send($urandom_range(0, 1), $urandom, s);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
    end
    idle(2);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule